// File: doc/BRIEF.md
# Per-Slot Immediate Compositing Router

This block sits in the second and third steps of a wide-issue instruction decoder. An instruction carries its immediate material in two packed blocks. The constant block holds bytes and the extension block holds 4-bit morsels. Each slot's share is laid contiguously after the share of the slot before it. Every operation slot has a 4-bit count field that says how many bytes and how many morsels it owns. The router turns this variable-length packing into a fixed layout: one 44-bit segment per slot, seven slots, a 308-bit compositing array.

The work is split over two clocked stages. The first stage reads all seven count fields, whether or not the instruction uses that many slots, and forms each slot's starting byte and morsel offsets as running sums. It registers those selects together with the two data blocks. The second stage uses the stored selects to steer bytes and morsels into each segment and writes zero wherever a slot owns nothing. Because offsets only accumulate upward, the counts read from unused trailing slots can only corrupt trailing segments, which later logic ignores. One instruction may enter on every clock.

Top module: `imm_composite_router`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and every bit of `comp_array` is 0 until a valid instruction reaches the output.
- R2: An instruction presented with `in_valid` high on a rising edge appears on `comp_array` with `out_valid` high exactly two rising edges later. Consecutive instructions on consecutive cycles come out on consecutive cycles, unmixed.
- R3: Bits [4k+1:4k] of `slot_counts` give slot k's byte count. Codes 0, 1 and 2 mean that many bytes, and code 3 means 4 bytes.
- R4: Slot k's bytes are read from `con_block` starting at byte index B_k, the sum of the byte counts of slots 0..k-1, where byte n is `con_block[8n+7:8n]`. Byte j of the slot goes to `comp_array[44k+8j+7:44k+8j]`.
- R5: Bits [4k+3:4k+2] of `slot_counts` give slot k's morsel count (0–3). The morsels start at morsel index M_k, the running sum of earlier morsel counts, where morsel n is `ext_block[4n+3:4n]`. Morsel j goes to `comp_array[44k+32+4j+3:44k+32+4j]`.
- R6: Every byte or morsel position at or beyond a slot's count is written as zero, whatever the data blocks contain.
- R7: Segment k depends only on the count fields of slots 0..k and on the data blocks. Changing the counts of later slots leaves it unchanged.
- R8: A cycle with `in_valid` low leaves `comp_array` unchanged two edges later and drops `out_valid`. Data-block and count changes presented in such a cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| slot_counts | input | 28 | Per-slot 4-bit count fields, slot 0 lowest |
| con_block | input | 224 | Isolated constant block, byte 0 lowest |
| ext_block | input | 84 | Isolated extension block, morsel 0 lowest |
| out_valid | output | 1 | Compositing array holds a new instruction |
| comp_array | output | 308 | Compositing array, slot 0 segment lowest |

## Verification
The hardest condition to reach from the ports is a full-capacity instruction. In that case every slot claims four bytes and three morsels, so the last slot's offsets land exactly on the final byte and morsel of each block. The stimulus drives that case on purpose, and it also drives a pass where only the trailing slots' counts change while the earlier counts stay fixed, to expose any dependence that runs the wrong way. Random counts and data follow back-to-back, with bubbles that scramble the inputs while `in_valid` is low. Every clock is compared against a behavioural model that computes the running sums directly.

// File: rtl/imm_composite_router.sv
module imm_composite_router #(
  parameter int NUM_SLOTS    = 7,
  parameter int SLOT_BYTES   = 4,
  parameter int SLOT_MORSELS = 3,
  parameter int MORSEL_W     = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [NUM_SLOTS*4-1:0]                slot_counts,
  input  logic [NUM_SLOTS*SLOT_BYTES*8-1:0]     con_block,
  input  logic [NUM_SLOTS*SLOT_MORSELS*MORSEL_W-1:0] ext_block,
  output logic                                  out_valid,
  output logic [NUM_SLOTS*(SLOT_BYTES*8+SLOT_MORSELS*MORSEL_W)-1:0] comp_array
);

  localparam int SEG_W     = SLOT_BYTES*8 + SLOT_MORSELS*MORSEL_W;
  localparam int ARR_W     = NUM_SLOTS*SEG_W;
  localparam int CON_BYTES = NUM_SLOTS*SLOT_BYTES;
  localparam int EXT_MORS  = NUM_SLOTS*SLOT_MORSELS;
  localparam int CON_W     = CON_BYTES*8;
  localparam int EXT_W     = EXT_MORS*MORSEL_W;
  localparam int BOFF_W    = $clog2(CON_BYTES+1);
  localparam int MOFF_W    = $clog2(EXT_MORS+1);
  localparam int BCNT_W    = $clog2(SLOT_BYTES+1);
  localparam int MCNT_W    = 2;

  logic [BOFF_W-1:0] boff_c [NUM_SLOTS];
  logic [MOFF_W-1:0] moff_c [NUM_SLOTS];
  logic [BCNT_W-1:0] bcnt_c [NUM_SLOTS];
  logic [MCNT_W-1:0] mcnt_c [NUM_SLOTS];

  always_comb begin
    logic [BOFF_W-1:0] bacc;
    logic [MOFF_W-1:0] macc;
    bacc = '0;
    macc = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      bcnt_c[k] = (slot_counts[4*k +: 2] == 2'd3) ? BCNT_W'(SLOT_BYTES)
                                                   : BCNT_W'(slot_counts[4*k +: 2]);
      mcnt_c[k] = slot_counts[4*k+2 +: 2];
      boff_c[k] = bacc;
      moff_c[k] = macc;
      bacc = bacc + BOFF_W'(bcnt_c[k]);
      macc = macc + MOFF_W'(mcnt_c[k]);
    end
  end

  logic              s1_valid;
  logic [BOFF_W-1:0] s1_boff [NUM_SLOTS];
  logic [MOFF_W-1:0] s1_moff [NUM_SLOTS];
  logic [BCNT_W-1:0] s1_bcnt [NUM_SLOTS];
  logic [MCNT_W-1:0] s1_mcnt [NUM_SLOTS];
  logic [CON_W-1:0]  s1_con;
  logic [EXT_W-1:0]  s1_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_con   <= '0;
      s1_ext   <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
        s1_boff[k] <= '0;
        s1_moff[k] <= '0;
        s1_bcnt[k] <= '0;
        s1_mcnt[k] <= '0;
      end
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_con <= con_block;
        s1_ext <= ext_block;
        for (int k = 0; k < NUM_SLOTS; k++) begin
          s1_boff[k] <= boff_c[k];
          s1_moff[k] <= moff_c[k];
          s1_bcnt[k] <= bcnt_c[k];
          s1_mcnt[k] <= mcnt_c[k];
        end
      end
    end
  end

  logic [ARR_W-1:0] comp_next;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    for (genvar j = 0; j < SLOT_BYTES; j++) begin : g_byte
      assign comp_next[k*SEG_W + 8*j +: 8] =
        (int'(s1_bcnt[k]) > j) ? 8'(s1_con >> (8*(int'(s1_boff[k]) + j))) : 8'h00;

      p_byte_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'($past(s1_bcnt[k])) <= j) |-> comp_array[k*SEG_W + 8*j +: 8] == 8'h00);
    end
    for (genvar j = 0; j < SLOT_MORSELS; j++) begin : g_mors
      assign comp_next[k*SEG_W + SLOT_BYTES*8 + MORSEL_W*j +: MORSEL_W] =
        (int'(s1_mcnt[k]) > j) ? MORSEL_W'(s1_ext >> (MORSEL_W*(int'(s1_moff[k]) + j)))
                               : {MORSEL_W{1'b0}};

      p_morsel_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'($past(s1_mcnt[k])) <= j)
        |-> comp_array[k*SEG_W + SLOT_BYTES*8 + MORSEL_W*j +: MORSEL_W] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      comp_array <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) comp_array <= comp_next;
    end
  end

  p_stage1_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $past(in_valid));
  p_stage2_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(comp_array));
  p_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (int'(s1_boff[NUM_SLOTS-1]) + int'(s1_bcnt[NUM_SLOTS-1]) <= CON_BYTES));

endmodule

// File: tb/imm_composite_router_tb.sv
module imm_composite_router_tb;
  localparam int NS = 7;
  localparam int ARR_W = NS*44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NS*4-1:0]  slot_counts = '0;
  logic [NS*32-1:0] con_block = '0;
  logic [NS*12-1:0] ext_block = '0;
  logic out_valid;
  logic [ARR_W-1:0] comp_array;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  imm_composite_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_counts(slot_counts),
    .con_block(con_block), .ext_block(ext_block),
    .out_valid(out_valid), .comp_array(comp_array));

  function automatic logic [ARR_W-1:0] ref_compose(logic [NS*4-1:0] cnt,
      logic [NS*32-1:0] con, logic [NS*12-1:0] ext);
    logic [ARR_W-1:0] a;
    int bo, mo, bc, mc;
    a = '0; bo = 0; mo = 0;
    for (int k = 0; k < NS; k++) begin
      bc = int'(cnt[4*k +: 2]);
      if (bc == 3) bc = 4;
      mc = int'(cnt[4*k+2 +: 2]);
      for (int j = 0; j < bc; j++) a[44*k + 8*j +: 8] = con[8*(bo+j) +: 8];
      for (int j = 0; j < mc; j++) a[44*k + 32 + 4*j +: 4] = ext[4*(mo+j) +: 4];
      bo += bc;
      mo += mc;
    end
    return a;
  endfunction

  logic [ARR_W-1:0] m_mid = '0, m_out = '0;
  logic m_mid_v = 1'b0, m_out_v = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mid_v <= 1'b0; m_out_v <= 1'b0; m_mid <= '0; m_out <= '0;
    end else begin
      m_mid_v <= in_valid;
      if (in_valid) m_mid <= ref_compose(slot_counts, con_block, ext_block);
      m_out_v <= m_mid_v;
      if (m_mid_v) m_out <= m_mid;
    end
  end

  always @(negedge clk) begin
    cycles++;
    compared++;
    if (out_valid !== m_out_v || comp_array !== m_out) begin
      mismatched++;
      $display("FAIL %s cycle %0d: out_valid=%0b comp_array=%h expected out_valid=%0b comp_array=%h",
               phase, cycles, out_valid, comp_array, m_out_v, m_out);
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic rand_data();
    for (int i = 0; i < NS; i++) con_block[32*i +: 32] = $urandom;
    for (int i = 0; i < NS; i++) ext_block[12*i +: 12] = 12'($urandom);
  endtask

  task automatic send(logic [NS*4-1:0] cnt, bit v);
    @(negedge clk);
    in_valid = v;
    slot_counts = cnt;
    rand_data();
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) send(28'($urandom), 1'b0);
  endtask

  initial begin
    phase = "R1";
    rand_data();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    phase = "R3";
    for (int c = 0; c < 4; c++) send(28'(c), 1'b1);
    for (int c = 0; c < 4; c++) send(28'(c) << 8, 1'b1);
    drain();

    phase = "R5";
    for (int c = 0; c < 4; c++) send(28'(c << 2), 1'b1);
    for (int c = 0; c < 4; c++) send(28'({c[1:0], 2'b01}) << 12, 1'b1);
    drain();

    phase = "R6";
    for (int i = 0; i < 4; i++) send('0, 1'b1);
    drain();

    phase = "R4";
    send({NS{4'hF}}, 1'b1);
    send({NS{4'hB}}, 1'b1);
    send({NS{4'h7}}, 1'b1);
    for (int i = 0; i < 30; i++) send(28'($urandom), 1'b1);
    drain();

    phase = "R7";
    for (int i = 0; i < 12; i++) send({16'($urandom), 12'h9E3}, 1'b1);
    drain();

    phase = "R2";
    for (int i = 0; i < 40; i++) send(28'($urandom), 1'b1);
    drain();

    phase = "R8";
    for (int i = 0; i < 40; i++) send(28'($urandom), 1'($urandom % 3 == 0));
    drain();

    phase = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || comp_array !== '0) begin
      mismatched++;
      $display("FAIL R1 reset: out_valid=%0b comp_array=%h expected 0 and all zero",
               out_valid, comp_array);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule